// File: doc/BRIEF.md
# Serial Shift-Register Cascade Output Driver

This block keeps a 24-bit output image and sends it to an external chain of serial-in, parallel-out shift registers over three wires: serial data, a shift clock and a store strobe. The image is organised as three 8-bit groups. A group mask selects which groups are physically present in the chain, and only the enabled groups are sent. A frame therefore carries 8, 16 or 24 bits.

The low fourteen image bits can each be handed to a hardware status source instead of the software value. Bits 1..0 can follow a two-bit line-modem status input. Bits 2..13 can follow four three-bit Ethernet PHY status inputs. A small write port loads the image, the group mask, the shift-clock polarity, the ownership enables and the shift-clock divider. A new frame is sent whenever the sent content would change, and again after a fixed idle interval. Each frame works from a snapshot, so register writes never disturb a frame already in progress.

Top module: `scd_cascade_drv`

## Requirements
- R1: At reset, the image takes the SHADOW_INIT parameter, the group mask takes GROUP_INIT, the divider takes DIV_INIT, all ownership enables clear and the falling-edge mode is chosen. While reset is held, `shift_clk` is 1 and `store_pulse` is 0. The first frame after reset sends this initial image.
- R2: A write with `wr_en` high stores `wr_data` by `wr_addr`:
  - 0: the image, bits 23..0.
  - 1: control. Bits 2..0 are the group mask, with mask bit g enabling image bits 8g+7..8g. Bit 3 set selects rising-edge mode. Bits 5..4 are the modem ownership enables.
  - 2: PHY ownership in bits 11..0.
  - 3: the divider in bits 7..0.
  - Addresses 4 to 7 change nothing and start no frame.
- R3: Each image bit is muxed before it is sent:
  - Image bit b (b = 0, 1) sends `dsl_status[b]` when modem enable b is set.
  - Image bit 2+3n+k sends `phy_status[3n+k]` when PHY enable bit 3n+k is set (n = 0..3, k = 0..2).
  - Every other bit sends the software image. A change on a status bit that is not owned starts no frame.
- R4: A frame sends the enabled groups from the highest-numbered group down, and each group MSB first. Disabled groups are skipped. The frame length is 8 times the number of enabled groups.
- R5: One shift-clock half period lasts divider+1 system cycles, so successive sampling edges are 2*(divider+1) cycles apart.
  - In falling-edge mode the clock idles at 1 and data is sampled on 1->0.
  - In rising-edge mode the clock idles at 0 and data is sampled on 0->1.
  - `ser_data` changes only when the clock returns to its idle level, or at frame start.
- R6: After the last bit's sampling edge and one further half period, `store_pulse` is 1 for 2*(divider+1) cycles. During that time the clock stays idle and `ser_data` holds.
- R7: A frame starts whenever the muxed image, the group mask or the polarity differs from the values last sent. Owned status changes therefore also start frames. A divider write alone starts none.
- R8: A write made during a frame does not alter that frame. It appears in the next frame, which starts right after the current one ends.
- R9: After REFRESH_CYC idle cycles with no frame, the current content is sent again.
- R10: With a group mask of 0, no frame is sent, `store_pulse` stays 0 and the clock stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 24 | Register write data |
| dsl_status | input | 2 | Line-modem status bits for image bits 1..0 |
| phy_status | input | 12 | Four 3-bit PHY status fields for image bits 13..2 |
| shift_clk | output | 1 | Shift clock to the register chain |
| ser_data | output | 1 | Serial data to the register chain |
| store_pulse | output | 1 | Store strobe that moves shifted data to the outputs |

## Verification
The bound checker watches the serial protocol on every cycle:
- `ser_data` moves only at a launch edge or at frame start.
- The clock moves only on a divider tick.
- The store strobe keeps the clock idle and the data steady.
- Frames start only from idle and with a nonzero mask.

Only the bench scenarios can show that the bit content and order of each frame match the muxed image, since this needs an independent model of ownership and group packing. The same holds for writes landing in the next frame rather than the current one, for divider-only writes, unowned status changes and unused addresses staying silent, and for the refresh interval.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int GRP_W  = 8;
  localparam int NGRP   = 3;
  localparam int IMG_W  = NGRP * GRP_W;
  localparam int DSL_W  = 2;
  localparam int PHY_W  = 3;
  localparam int N_PHY  = 4;
  localparam int OWN_W  = DSL_W + PHY_W * N_PHY;
  localparam int LEN_W  = $clog2(IMG_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_STORE} shift_state_t;

  typedef struct packed {
    logic [IMG_W-1:0] img;
    logic [NGRP-1:0]  mask;
    logic             rise;
  } frame_key_t;

  // Enabled groups packed toward the MSB, highest group first.
  function automatic logic [IMG_W-1:0] pack_frame(input logic [IMG_W-1:0] img,
                                                  input logic [NGRP-1:0] mask);
    logic [IMG_W-1:0] r;
    int pos;
    r   = '0;
    pos = IMG_W;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (mask[g]) begin
        pos = pos - GRP_W;
        r[pos +: GRP_W] = img[g*GRP_W +: GRP_W];
      end
    end
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [NGRP-1:0] mask);
    return LEN_W'($countones(mask) * GRP_W);
  endfunction
endpackage

// File: rtl/scd_regs.sv
module scd_regs
  import scd_pkg::*;
#(
  parameter int               ADDR_W      = 3,
  parameter int               DIV_W       = 8,
  parameter logic [IMG_W-1:0] SHADOW_INIT = '0,
  parameter logic [NGRP-1:0]  GROUP_INIT  = '1,
  parameter logic [DIV_W-1:0] DIV_INIT    = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [IMG_W-1:0]       wr_data,
  output logic [IMG_W-1:0]       sw_img,
  output logic [NGRP-1:0]        grp_mask,
  output logic                   rise_mode,
  output logic [DSL_W-1:0]       dsl_own,
  output logic [PHY_W*N_PHY-1:0] phy_own,
  output logic [DIV_W-1:0]       div_val
);
  localparam logic [ADDR_W-1:0] A_IMAGE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PHY   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(3);
  localparam int CTRL_RISE = NGRP;
  localparam int CTRL_DSL  = NGRP + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_img    <= SHADOW_INIT;
      grp_mask  <= GROUP_INIT;
      rise_mode <= 1'b0;
      dsl_own   <= '0;
      phy_own   <= '0;
      div_val   <= DIV_INIT;
    end else if (wr_en) begin
      case (wr_addr)
        A_IMAGE: sw_img <= wr_data;
        A_CTRL: begin
          grp_mask  <= wr_data[NGRP-1:0];
          rise_mode <= wr_data[CTRL_RISE];
          dsl_own   <= wr_data[CTRL_DSL +: DSL_W];
        end
        A_PHY:   phy_own <= wr_data[PHY_W*N_PHY-1:0];
        A_DIV:   div_val <= wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scd_own_mux.sv
module scd_own_mux
  import scd_pkg::*;
(
  input  logic [IMG_W-1:0]       sw_img,
  input  logic [DSL_W-1:0]       dsl_own,
  input  logic [PHY_W*N_PHY-1:0] phy_own,
  input  logic [DSL_W-1:0]       dsl_status,
  input  logic [PHY_W*N_PHY-1:0] phy_status,
  output logic [IMG_W-1:0]       out_img
);
  // PHY n owns image bits 2+3n .. 2+3n+2, directly above the modem bits.
  logic [OWN_W-1:0] own_en;
  logic [OWN_W-1:0] own_val;
  assign own_en  = {phy_own, dsl_own};
  assign own_val = {phy_status, dsl_status};

  for (genvar b = 0; b < IMG_W; b++) begin : g_bit
    if (b < OWN_W) begin : g_owned
      assign out_img[b] = own_en[b] ? own_val[b] : sw_img[b];
    end else begin : g_plain
      assign out_img[b] = sw_img[b];
    end
  end
endmodule

// File: rtl/scd_shifter.sv
module scd_shifter
  import scd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IMG_W-1:0] word,
  input  logic [LEN_W-1:0] len,
  input  logic             pol,
  input  logic [DIV_W-1:0] div,
  output logic             shift_clk,
  output logic             ser_data,
  output logic             store_pulse,
  output logic             busy,
  output logic             tick,
  output logic             bit_launch,
  output logic             frame_pol
);
  shift_state_t     state;
  logic             phase;
  logic [DIV_W-1:0] cnt, div_q;
  logic [IMG_W-1:0] shreg;
  logic [LEN_W-1:0] left;

  assign busy       = (state != ST_IDLE);
  assign tick       = busy && (cnt == div_q);
  assign bit_launch = (state == ST_SHIFT) && tick && phase && (left != '0);
  assign shift_clk  = ((state == ST_SHIFT) && phase) ? frame_pol : ~frame_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase       <= 1'b0;
      cnt         <= '0;
      div_q       <= '0;
      shreg       <= '0;
      left        <= '0;
      ser_data    <= 1'b0;
      store_pulse <= 1'b0;
      frame_pol   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_SHIFT;
          ser_data  <= word[IMG_W-1];
          shreg     <= word << 1;
          left      <= len - LEN_W'(1);
          phase     <= 1'b0;
          cnt       <= '0;
          frame_pol <= pol;
          div_q     <= div;
        end
        ST_SHIFT: begin
          if (!tick) cnt <= cnt + DIV_W'(1);
          else begin
            cnt <= '0;
            if (!phase) phase <= 1'b1;
            else if (left == '0) begin
              state       <= ST_STORE;
              phase       <= 1'b0;
              store_pulse <= 1'b1;
            end else begin
              phase    <= 1'b0;
              ser_data <= shreg[IMG_W-1];
              shreg    <= shreg << 1;
              left     <= left - LEN_W'(1);
            end
          end
        end
        default: begin
          if (!tick) cnt <= cnt + DIV_W'(1);
          else begin
            cnt <= '0;
            if (!phase) phase <= 1'b1;
            else begin
              state       <= ST_IDLE;
              phase       <= 1'b0;
              store_pulse <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scd_cascade_drv.sv
module scd_cascade_drv
  import scd_pkg::*;
#(
  parameter int               DIV_W       = 8,
  parameter logic [IMG_W-1:0] SHADOW_INIT = '0,
  parameter logic [NGRP-1:0]  GROUP_INIT  = '1,
  parameter logic [DIV_W-1:0] DIV_INIT    = 1,
  parameter int               REFRESH_CYC = 1000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [IMG_W-1:0]       wr_data,
  input  logic [DSL_W-1:0]       dsl_status,
  input  logic [PHY_W*N_PHY-1:0] phy_status,
  output logic                   shift_clk,
  output logic                   ser_data,
  output logic                   store_pulse
);
  localparam int RF_W = $clog2(REFRESH_CYC);
  localparam logic [RF_W-1:0] RF_LAST = RF_W'(REFRESH_CYC - 1);

  logic [IMG_W-1:0]       sw_img, muxed;
  logic [NGRP-1:0]        grp_mask;
  logic                   rise_mode;
  logic [DSL_W-1:0]       dsl_own;
  logic [PHY_W*N_PHY-1:0] phy_own;
  logic [DIV_W-1:0]       div_val;
  logic                   busy, sh_tick, bit_launch, frame_pol;
  logic                   frame_start, refresh_due, dirty;
  logic [RF_W-1:0]        idle_cnt;
  frame_key_t             cur_key, last_key;

  scd_regs #(.ADDR_W(3), .DIV_W(DIV_W), .SHADOW_INIT(SHADOW_INIT),
             .GROUP_INIT(GROUP_INIT), .DIV_INIT(DIV_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_img(sw_img), .grp_mask(grp_mask), .rise_mode(rise_mode),
    .dsl_own(dsl_own), .phy_own(phy_own), .div_val(div_val));

  scd_own_mux u_mux (
    .sw_img(sw_img), .dsl_own(dsl_own), .phy_own(phy_own),
    .dsl_status(dsl_status), .phy_status(phy_status), .out_img(muxed));

  assign cur_key     = '{img: muxed, mask: grp_mask, rise: rise_mode};
  assign refresh_due = (idle_cnt == RF_LAST);
  assign frame_start = !busy && (grp_mask != '0) &&
                       (dirty || (cur_key != last_key) || refresh_due);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty    <= 1'b1;
      last_key <= '0;
      idle_cnt <= '0;
    end else if (frame_start) begin
      dirty    <= 1'b0;
      last_key <= cur_key;
      idle_cnt <= '0;
    end else if (!busy && !refresh_due) begin
      idle_cnt <= idle_cnt + RF_W'(1);
    end
  end

  scd_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(frame_start),
    .word(pack_frame(muxed, grp_mask)), .len(frame_len(grp_mask)),
    .pol(rise_mode), .div(div_val),
    .shift_clk(shift_clk), .ser_data(ser_data), .store_pulse(store_pulse),
    .busy(busy), .tick(sh_tick), .bit_launch(bit_launch), .frame_pol(frame_pol));
endmodule

// File: rtl/scd_checker.sv
module scd_checker
  import scd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            shift_clk,
  input logic            ser_data,
  input logic            store_pulse,
  input logic            busy,
  input logic            frame_start,
  input logic            tick,
  input logic            bit_launch,
  input logic            frame_pol,
  input logic [NGRP-1:0] grp_mask
);
  assert_no_empty_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (grp_mask != '0));

  assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !busy);

  assert_store_clk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |-> (shift_clk == ~frame_pol));

  assert_store_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pulse && $past(store_pulse)) |-> $stable(ser_data));

  assert_data_launch_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_launch && !frame_start) |=> $stable(ser_data));

  assert_clk_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !frame_start) |=> $stable(shift_clk));
endmodule

bind scd_cascade_drv scd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_data(ser_data),
  .store_pulse(store_pulse), .busy(busy), .frame_start(frame_start),
  .tick(sh_tick), .bit_launch(bit_launch), .frame_pol(frame_pol),
  .grp_mask(grp_mask));

// File: tb/tb_scd_cascade_drv.sv
module tb_scd_cascade_drv;
  localparam logic [23:0] SHADOW = 24'hA53C96;
  localparam int REFRESH = 1500;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [23:0] wr_data = 0;
  logic [1:0] dsl_st = 0;
  logic [11:0] phy_st = 0;
  logic shift_clk, ser_data, store_pulse;

  always #5 clk = ~clk;

  scd_cascade_drv #(.SHADOW_INIT(SHADOW), .GROUP_INIT(3'b111), .DIV_INIT(8'd1),
                    .REFRESH_CYC(REFRESH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dsl_status(dsl_st), .phy_status(phy_st), .shift_clk(shift_clk),
    .ser_data(ser_data), .store_pulse(store_pulse));

  typedef struct { logic [23:0] bits; int len; bit rise; int div; } exp_t;
  exp_t q[$];

  int vectors = 0, fails = 0, frames_seen = 0, cyc = 0;
  logic [23:0] m_img = SHADOW;
  logic [2:0] m_mask = 3'b111;
  bit m_rise = 0;
  logic [1:0] m_dsl = 0;
  logic [11:0] m_phy = 0;
  int m_div = 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Expected muxed bit: R3 ownership map computed per bit.
  function automatic logic exp_bit(input int b);
    int n, k;
    if (b < 2) return m_dsl[b] ? dsl_st[b] : m_img[b];
    if (b < 14) begin
      n = (b - 2) / 3; k = (b - 2) % 3;
      return m_phy[3*n+k] ? phy_st[3*n+k] : m_img[b];
    end
    return m_img[b];
  endfunction

  // R4: groups high to low, MSB first, kept MSB-aligned.
  task automatic push_expect();
    exp_t e;
    int p = 23;
    e.bits = 0; e.len = 0; e.rise = m_rise; e.div = m_div;
    for (int g = 2; g >= 0; g--)
      if (m_mask[g])
        for (int i = 7; i >= 0; i--) begin
          e.bits[p] = exp_bit(8*g + i); p--; e.len++;
        end
    q.push_back(e);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    case (a)
      3'd0: m_img = d;
      3'd1: begin m_mask = d[2:0]; m_rise = d[3]; m_dsl = d[5:4]; end
      3'd2: m_phy = d[11:0];
      3'd3: m_div = int'(d[7:0]);
      default: ;
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drain(input int limit, input string tag);
    int i;
    for (i = 0; i < limit; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !store_pulse) break;
    end
    check(i < limit, {tag, " frame delivered"}, q.size(), 0);
  endtask

  task automatic quiet(input int n, input string tag);
    int f0 = frames_seen;
    bit busy_seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (store_pulse || shift_clk != !m_rise) busy_seen = 1;
    end
    check(frames_seen == f0 && !busy_seen, {tag, " no frame"}, frames_seen - f0, 0);
  endtask

  // Monitor: rebuild each frame from the sampling edges, compare on store.
  bit prev_clk = 1, prev_store = 0, stab_bad = 0, have_fr = 0;
  logic [23:0] got = 0;
  logic held = 0;
  int nbits = 0, last_samp = 0, store_w = 0;
  exp_t fr;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_clk = shift_clk; prev_store = 0; nbits = 0; got = 0;
    end else begin
      if (q.size() != 0 && !store_pulse &&
          (q[0].rise ? (!prev_clk && shift_clk) : (prev_clk && !shift_clk))) begin
        if (nbits > 0)
          check(cyc - last_samp == 2*(q[0].div+1), "R5 sample spacing",
                cyc - last_samp, 2*(q[0].div+1));
        last_samp = cyc; got = {got[22:0], ser_data}; nbits++;
      end
      if (store_pulse && !prev_store) begin
        frames_seen++;
        store_w = 0; stab_bad = 0; held = ser_data;
        if (q.size() == 0) begin
          have_fr = 0;
          check(0, "R7 unexpected frame", nbits, 0);
        end else begin
          fr = q[0]; have_fr = 1;
          check(nbits == fr.len, "R4 frame length", nbits, fr.len);
          check((longint'(got) & ((64'd1 << fr.len) - 1)) == longint'(fr.bits >> (24 - fr.len)),
                "R3/R4 frame bits", got, fr.bits >> (24 - fr.len));
        end
      end
      if (store_pulse) begin
        store_w++;
        if (ser_data != held || (have_fr && shift_clk != !fr.rise)) stab_bad = 1;
      end
      if (!store_pulse && prev_store) begin
        if (have_fr) begin
          check(store_w == 2*(fr.div+1), "R6 store width", store_w, 2*(fr.div+1));
          check(!stab_bad, "R6 data/clock held in store", stab_bad, 0);
          void'(q.pop_front());
        end
        have_fr = 0; nbits = 0; got = 0;
      end
      prev_clk = shift_clk; prev_store = store_pulse;
    end
  end

  always @(negedge clk)
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end

  initial begin
    int t0;
    push_expect();
    repeat (3) @(negedge clk);
    check(shift_clk == 1 && store_pulse == 0, "R1 reset outputs", {shift_clk, store_pulse}, 2'b10);
    rst_n = 1;
    drain(2000, "R1 shadow");

    reg_write(3'd1, 24'h05); push_expect(); drain(2000, "R4 groups 2,0");
    reg_write(3'd1, 24'h0A); push_expect(); drain(2000, "R5 rising group 1");

    reg_write(3'd3, 24'd3); quiet(300, "R7 divider only");
    reg_write(3'd0, 24'h123456); push_expect(); drain(3000, "R5 divider 3");

    dsl_st = 2'b01;
    reg_write(3'd1, 24'h37); push_expect(); drain(3000, "R3 modem own");
    phy_st = 12'b010_110_001_101;
    reg_write(3'd2, 24'b101_000_011_110); push_expect(); drain(3000, "R3 phy own");

    @(negedge clk); push_expect(); phy_st[1] = ~phy_st[1]; m_phy = m_phy;
    q[q.size()-1].bits = 0; void'(q.pop_back()); push_expect();
    drain(3000, "R7 owned status");
    @(negedge clk); phy_st[0] = ~phy_st[0]; quiet(300, "R3 unowned status");
    reg_write(3'd5, 24'hFFFFFF); quiet(300, "R2 unused address");

    reg_write(3'd0, 24'hC0FFEE); push_expect();
    repeat (20) @(negedge clk);
    reg_write(3'd0, 24'h0F0F0F); push_expect();
    drain(5000, "R8 mid-frame write");

    reg_write(3'd1, 24'h00); quiet(300, "R10 empty mask");
    reg_write(3'd1, 24'h07); push_expect(); drain(3000, "R10 mask restored");

    t0 = cyc; push_expect(); drain(4000, "R9 refresh");
    check(cyc - t0 >= REFRESH - 10, "R9 refresh interval", cyc - t0, REFRESH);

    reg_write(3'd3, 24'd0); reg_write(3'd0, 24'h800001); push_expect(); drain(2000, "R5 divider 0");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule